// File: doc/BRIEF.md
# Dual Synchronous-Frame Power-Factor Tracker with Clamp-Shift Scheduler

This block receives one strobe-qualified set of three-phase voltage samples and three-phase current samples per control period. Each set goes through its own phase-locked loop. The samples are projected onto a two-axis stationary frame and then rotated by the loop's own angle estimate. A proportional-integral controller drives the quadrature term toward zero and feeds a 32-bit phase accumulator. The direct term is smoothed by a first-order filter and is reported as the fundamental amplitude.

The difference between the two loop angles is the displacement angle between the fundamental voltage and the fundamental current, with a lagging current counted as positive. A piecewise schedule maps that angle to the phase-shift command that a discontinuous-PWM modulator uses to place its bus-clamp window. The command changes only on a sample strobe. While either loop is out of lock, the command stays at a safe 60° value.

Top module: `pf_shift_estimator`

## Requirements
- R1: When a loop is locked, `v_amp` and `i_amp` equal the peak amplitude of the respective balanced three-phase input, within 3 %.
- R2: When both loops are locked, `pf_angle` equals the voltage phase minus the current phase, within 2°. It is a signed 16-bit angle with 65536 counts per turn, and a lagging current gives a positive value.
- R3: `locked` rises only after both loops' filtered quadrature magnitudes have stayed below `LOCK_THR` for `LOCK_SAMPLES` consecutive strobes (256 by default). It falls on the first strobe at which either magnitude reaches the threshold.
- R4: A strobe that finds `locked` low loads `shift_angle` with 60° (10923 counts).
- R5: When locked and |pf_angle| < 30°, the shift magnitude is 90° minus |pf_angle|.
- R6: When locked and 30° ≤ |pf_angle| ≤ 60°, the shift magnitude is 60°.
- R7: When locked, the shift magnitude is 120° minus |pf_angle| for 60° < |pf_angle| < 90°, and 30° (5461 counts) for |pf_angle| ≥ 90°. The magnitude therefore never leaves the range 30°..90°.
- R8: A negative `pf_angle` (leading current) gives the negated shift, and a zero or positive angle gives a positive shift.
- R9: `shift_angle` and `pf_angle` change only in the cycle after a `sample_stb` pulse.
- R10: After reset, `locked` is 0, `shift_angle` is 10923, and `pf_angle`, `v_amp` and `i_amp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle pulse marking a valid sample set |
| v_a | input | DW | Phase A voltage sample, signed |
| v_b | input | DW | Phase B voltage sample, signed |
| v_c | input | DW | Phase C voltage sample, signed |
| i_a | input | DW | Phase A current sample, signed |
| i_b | input | DW | Phase B current sample, signed |
| i_c | input | DW | Phase C current sample, signed |
| shift_angle | output | 16 | Clamp phase-shift command, signed, 65536 counts per turn |
| pf_angle | output | 16 | Displacement angle, voltage minus current, signed |
| locked | output | 1 | Both loops locked |
| v_amp | output | DW+4 | Filtered fundamental voltage amplitude, signed |
| i_amp | output | DW+4 | Filtered fundamental current amplitude, signed |

## Verification
The checker watches four properties on every cycle:
- Both outputs hold steady between strobes.
- An unlocked update loads the 60° value.
- `locked` is never high while either filtered quadrature term is at or above the threshold.
- The shift magnitude stays within 30°..90°, and its sign follows the sign of the angle whenever the last update was made under lock.

Only the bench scenarios can show the remaining behaviour. These are the loops actually converging on sinusoidal inputs, the amplitude and angle accuracy, the exact value of each segment of the schedule across leading and lagging loads, the lock count after reset, and the loss of lock after a sudden current phase step.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
    localparam int ANG_W = 16;
    typedef logic signed [ANG_W-1:0] angle_t;

    // Angles in counts of a 65536-per-turn circle, one bit wider for magnitudes
    localparam logic signed [ANG_W:0] ANG_30  = 17'sd5461;
    localparam logic signed [ANG_W:0] ANG_60  = 17'sd10923;
    localparam logic signed [ANG_W:0] ANG_90  = 17'sd16384;
    localparam logic signed [ANG_W:0] ANG_120 = 17'sd21845;
endpackage

// File: rtl/pfe_sincos.sv
module pfe_sincos #(
    parameter int LUT_BITS = 10,
    parameter int AMP_W    = 16
) (
    input  logic [LUT_BITS-1:0]     addr,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);
    localparam int QB   = LUT_BITS - 2;
    localparam int QN   = 1 << QB;
    localparam int FULL = (1 << (AMP_W - 1)) - 1;

    // Quarter-wave entry k holds sin((k+0.5) * quarter / QN), so ~k mirrors exactly
    function automatic int quarter_sine(input int k);
        real x, x2, s;
        x  = (real'(k) + 0.5) * 3.14159265358979 / (2.0 * real'(QN));
        x2 = x * x;
        s  = x * (1.0 - x2 / 6.0 * (1.0 - x2 / 20.0 * (1.0 - x2 / 42.0 * (1.0 - x2 / 72.0))));
        return $rtoi(s * real'(FULL) + 0.5);
    endfunction

    logic [AMP_W-2:0] rom [QN];

    for (genvar g = 0; g < QN; g++) begin : g_rom
        localparam int VAL = quarter_sine(g);
        assign rom[g] = VAL[AMP_W-2:0];
    end

    logic [1:0]       quad_s, quad_c;
    logic [QB-1:0]    idx;
    logic [AMP_W-2:0] mag_s, mag_c;
    logic signed [AMP_W-1:0] pos_s, pos_c;

    assign idx    = addr[QB-1:0];
    assign quad_s = addr[LUT_BITS-1 -: 2];
    assign quad_c = quad_s + 2'd1;
    assign mag_s  = rom[quad_s[0] ? ~idx : idx];
    assign mag_c  = rom[quad_c[0] ? ~idx : idx];
    assign pos_s  = {1'b0, mag_s};
    assign pos_c  = {1'b0, mag_c};
    assign sin_o  = quad_s[1] ? -pos_s : pos_s;
    assign cos_o  = quad_c[1] ? -pos_c : pos_c;
endmodule

// File: rtl/pfe_srf_loop.sv
module pfe_srf_loop
    import pfe_pkg::*;
#(
    parameter int               DW           = 16,
    parameter int               PH_W         = 32,
    parameter int               LUT_BITS     = 10,
    parameter logic [PH_W-1:0]  NOM_STEP     = 32'd4194304,
    parameter int               KP_SHL       = 10,
    parameter int               KI_SHL       = 2,
    parameter int               LPF_SH       = 4,
    parameter int               LOCK_THR     = 400,
    parameter int               LOCK_SAMPLES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb,
    input  logic signed [DW-1:0] x_a,
    input  logic signed [DW-1:0] x_b,
    input  logic signed [DW-1:0] x_c,
    output logic [ANG_W-1:0]     theta,
    output logic signed [DW+3:0] amp,
    output logic signed [DW+3:0] q_filt,
    output logic                 lock
);
    localparam int PW        = DW + 4;
    localparam int TW        = DW + 20;
    localparam int CW        = $clog2(LOCK_SAMPLES + 1);
    localparam int AMP_W     = 16;
    localparam int ONE_THIRD = 21845;   // 65536 / 3
    localparam int INV_SQRT3 = 37837;   // 65536 / sqrt(3)

    typedef struct packed {
        logic [PH_W-1:0]        phase;
        logic signed [PH_W-1:0] integ;
        logic signed [PW-1:0]   d_f;
        logic signed [PW-1:0]   q_f;
        logic [CW-1:0]          cnt;
        logic                   lock;
    } loop_t;

    loop_t st_q, st_d;

    logic signed [AMP_W-1:0] sn, cs;

    pfe_sincos #(.LUT_BITS(LUT_BITS), .AMP_W(AMP_W)) u_sincos (
        .addr  (st_q.phase[PH_W-1 -: LUT_BITS]),
        .sin_o (sn),
        .cos_o (cs)
    );

    // Stationary-frame projection, amplitude invariant
    logic signed [DW+2:0] sum3;
    logic signed [DW+1:0] dbc;
    logic signed [TW-1:0] prod_a, prod_b;
    logic signed [DW:0]   alpha, beta;

    assign sum3   = (DW+3)'(x_a) + (DW+3)'(x_a) - (DW+3)'(x_b) - (DW+3)'(x_c);
    assign dbc    = (DW+2)'(x_b) - (DW+2)'(x_c);
    assign prod_a = TW'(sum3) * TW'(ONE_THIRD);
    assign prod_b = TW'(dbc) * TW'(INV_SQRT3);
    assign alpha  = (DW+1)'(prod_a >>> 16);
    assign beta   = (DW+1)'(prod_b >>> 16);

    // Rotation by the tracked angle
    logic signed [TW-1:0] pd, pq;
    logic signed [PW-1:0] d_raw, q_raw;

    assign pd    = TW'(alpha) * TW'(cs) + TW'(beta) * TW'(sn);
    assign pq    = TW'(beta) * TW'(cs) - TW'(alpha) * TW'(sn);
    assign d_raw = PW'(pd >>> (AMP_W - 1));
    assign q_raw = PW'(pq >>> (AMP_W - 1));

    // Proportional-integral controller feeding the phase accumulator
    logic signed [PH_W-1:0] q_ext, integ_n, step;
    assign q_ext   = PH_W'(q_raw);
    assign integ_n = st_q.integ + (q_ext <<< KI_SHL);
    assign step    = $signed(NOM_STEP) + integ_n + (q_ext <<< KP_SHL);

    // First-order smoothing of both axes
    logic signed [PW:0]   dd, dq;
    logic signed [PW-1:0] d_f_n, q_f_n;
    logic [PW-1:0]        q_mag;
    logic                 quiet;

    assign dd    = (PW+1)'(d_raw) - (PW+1)'(st_q.d_f);
    assign dq    = (PW+1)'(q_raw) - (PW+1)'(st_q.q_f);
    assign d_f_n = st_q.d_f + PW'(dd >>> LPF_SH);
    assign q_f_n = st_q.q_f + PW'(dq >>> LPF_SH);
    assign q_mag = q_f_n[PW-1] ? PW'(-q_f_n) : PW'(q_f_n);
    assign quiet = q_mag < PW'(LOCK_THR);

    always_comb begin
        st_d = st_q;
        if (stb) begin
            st_d.phase = st_q.phase + PH_W'(step);
            st_d.integ = integ_n;
            st_d.d_f   = d_f_n;
            st_d.q_f   = q_f_n;
            if (quiet) begin
                st_d.cnt = (st_q.cnt == CW'(LOCK_SAMPLES)) ? st_q.cnt : st_q.cnt + CW'(1);
            end else begin
                st_d.cnt = '0;
            end
            st_d.lock = quiet && (st_d.cnt == CW'(LOCK_SAMPLES));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign theta  = st_q.phase[PH_W-1 -: ANG_W];
    assign amp    = st_q.d_f;
    assign q_filt = st_q.q_f;
    assign lock   = st_q.lock;
endmodule

// File: rtl/pfe_shift_map.sv
module pfe_shift_map
    import pfe_pkg::*;
(
    input  angle_t pf_i,
    output angle_t shift_o
);
    logic signed [ANG_W:0] ext, mag, sched;

    always_comb begin
        ext = (ANG_W+1)'(pf_i);
        mag = ext[ANG_W] ? -ext : ext;
        if (mag < ANG_30) begin
            sched = ANG_90 - mag;          // clamp window follows the current peak
        end else if (mag <= ANG_60) begin
            sched = ANG_60;
        end else if (mag < ANG_90) begin
            sched = ANG_120 - mag;         // split clamping region
        end else begin
            sched = ANG_30;
        end
        shift_o = pf_i[ANG_W-1] ? ANG_W'(-sched) : ANG_W'(sched);
    end
endmodule

// File: rtl/pf_shift_estimator.sv
module pf_shift_estimator
    import pfe_pkg::*;
#(
    parameter int               DW           = 16,
    parameter int               PH_W         = 32,
    parameter int               LUT_BITS     = 10,
    parameter logic [PH_W-1:0]  NOM_STEP     = 32'd4194304,
    parameter int               KP_SHL       = 10,
    parameter int               KI_SHL       = 2,
    parameter int               LPF_SH       = 4,
    parameter int               LOCK_THR     = 400,
    parameter int               LOCK_SAMPLES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_stb,
    input  logic signed [DW-1:0] v_a,
    input  logic signed [DW-1:0] v_b,
    input  logic signed [DW-1:0] v_c,
    input  logic signed [DW-1:0] i_a,
    input  logic signed [DW-1:0] i_b,
    input  logic signed [DW-1:0] i_c,
    output logic signed [15:0]   shift_angle,
    output logic signed [15:0]   pf_angle,
    output logic                 locked,
    output logic signed [DW+3:0] v_amp,
    output logic signed [DW+3:0] i_amp
);
    logic [ANG_W-1:0]     v_th, i_th;
    logic signed [DW+3:0] v_qf, i_qf;
    logic                 v_lock, i_lock;

    typedef enum logic [0:0] { SRC_VOLT = 1'b0, SRC_CURR = 1'b1 } src_e;

    for (genvar s = 0; s < 2; s++) begin : g_loop
        localparam src_e SRC = src_e'(s);
        logic [ANG_W-1:0]     th;
        logic signed [DW+3:0] am, qf;
        logic                 lk;

        pfe_srf_loop #(
            .DW(DW), .PH_W(PH_W), .LUT_BITS(LUT_BITS), .NOM_STEP(NOM_STEP),
            .KP_SHL(KP_SHL), .KI_SHL(KI_SHL), .LPF_SH(LPF_SH),
            .LOCK_THR(LOCK_THR), .LOCK_SAMPLES(LOCK_SAMPLES)
        ) u_loop (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (sample_stb),
            .x_a    (SRC == SRC_VOLT ? v_a : i_a),
            .x_b    (SRC == SRC_VOLT ? v_b : i_b),
            .x_c    (SRC == SRC_VOLT ? v_c : i_c),
            .theta  (th),
            .amp    (am),
            .q_filt (qf),
            .lock   (lk)
        );
    end

    assign v_th   = g_loop[0].th;
    assign i_th   = g_loop[1].th;
    assign v_amp  = g_loop[0].am;
    assign i_amp  = g_loop[1].am;
    assign v_qf   = g_loop[0].qf;
    assign i_qf   = g_loop[1].qf;
    assign v_lock = g_loop[0].lk;
    assign i_lock = g_loop[1].lk;
    assign locked = v_lock & i_lock;

    typedef struct packed {
        angle_t shift;
        angle_t pf;
    } out_t;

    out_t   out_q, out_d;
    angle_t pf_now, sched;

    assign pf_now = angle_t'(v_th - i_th);

    pfe_shift_map u_map (
        .pf_i    (pf_now),
        .shift_o (sched)
    );

    always_comb begin
        out_d = out_q;
        if (sample_stb) begin
            out_d.pf    = pf_now;
            out_d.shift = locked ? sched : ANG_W'(ANG_60);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.shift <= ANG_W'(ANG_60);
            out_q.pf    <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign shift_angle = out_q.shift;
    assign pf_angle    = out_q.pf;
endmodule

// File: rtl/pfe_checker.sv
module pfe_checker
    import pfe_pkg::*;
#(
    parameter int DW       = 16,
    parameter int LOCK_THR = 400
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 stb,
    input logic signed [15:0]   shift,
    input logic signed [15:0]   pf,
    input logic                 locked,
    input logic signed [DW+3:0] v_qf,
    input logic signed [DW+3:0] i_qf
);
    function automatic logic [DW+3:0] mag_of(input logic signed [DW+3:0] x);
        return x[DW+3] ? (DW+4)'(-x) : (DW+4)'(x);
    endfunction

    logic upd_locked_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_locked_q <= 1'b0;
        end else if (stb) begin
            upd_locked_q <= locked;
        end
    end

    logic signed [16:0] shift_mag;
    assign shift_mag = shift[15] ? -(17'(shift)) : 17'(shift);

    assert_hold_between_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stb) |-> ($stable(shift) && $stable(pf)));

    assert_unlocked_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stb) && !$past(locked)) |-> (shift == 16'sd10923));

    assert_lock_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> ((mag_of(v_qf) < (DW+4)'(LOCK_THR)) && (mag_of(i_qf) < (DW+4)'(LOCK_THR))));

    assert_lock_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(stb));

    assert_shift_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_mag >= ANG_30) && (shift_mag <= ANG_90));

    assert_mirror_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_locked_q |-> ((pf < 0) == (shift < 0)));
endmodule

bind pf_shift_estimator pfe_checker #(.DW(DW), .LOCK_THR(LOCK_THR)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (sample_stb),
    .shift  (shift_angle),
    .pf     (pf_angle),
    .locked (locked),
    .v_qf   (v_qf),
    .i_qf   (i_qf)
);

// File: tb/pf_shift_estimator_tb.sv
`timescale 1ns/1ps
module pf_shift_estimator_tb;
    localparam int  DW     = 16;
    localparam int  PER    = 1000;
    localparam int  SETTLE = 4000;
    localparam int  NV     = 10;
    localparam real PI     = 3.14159265358979;
    localparam int  TOL    = 364;   // 2 degrees in counts

    // Walked vectors: lag angle in degrees, expected shift in degrees, current amplitude
    localparam int VEC_PF [NV] = '{0, 15, -20, 45, -35, 70, 80, -75, 100, -100};
    localparam int VEC_SH [NV] = '{90, 75, -70, 60, -60, 50, 40, -45, 30, -30};
    localparam int VEC_IA [NV] = '{8000, 12000, 9000, 14000, 10000, 8000, 11000, 13000, 9000, 10000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb = 1'b0;
    logic signed [DW-1:0] va = '0, vb = '0, vc = '0, ia = '0, ib = '0, ic = '0;
    logic signed [15:0]   shift_angle, pf_angle;
    logic                 locked;
    logic signed [DW+3:0] v_amp, i_amp;

    always #2.5 clk = ~clk;

    pf_shift_estimator u_dut (
        .clk(clk), .rst_n(rst_n), .sample_stb(stb),
        .v_a(va), .v_b(vb), .v_c(vc), .i_a(ia), .i_b(ib), .i_c(ic),
        .shift_angle(shift_angle), .pf_angle(pf_angle), .locked(locked),
        .v_amp(v_amp), .i_amp(i_amp)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    int  t_s = 0;
    real v_pk = 16000.0;
    real i_pk = 8000.0;
    real i_lag = 0.0;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int deg2u(input real d);
        return $rtoi(d * 65536.0 / 360.0 + ((d >= 0.0) ? 0.5 : -0.5));
    endfunction

    function automatic int ang_err(input int act, input int exp);
        logic signed [15:0] e;
        e = 16'(act - exp);
        return (e < 0) ? -int'(e) : int'(e);
    endfunction

    task automatic run_samples(input int n);
        for (int k = 0; k < n; k++) begin
            real th;
            @(negedge clk);
            th = 2.0 * PI * real'(t_s) / real'(PER);
            va = 16'(int'(v_pk * $cos(th)));
            vb = 16'(int'(v_pk * $cos(th - 2.0 * PI / 3.0)));
            vc = 16'(int'(v_pk * $cos(th + 2.0 * PI / 3.0)));
            ia = 16'(int'(i_pk * $cos(th - i_lag)));
            ib = 16'(int'(i_pk * $cos(th - i_lag - 2.0 * PI / 3.0)));
            ic = 16'(int'(i_pk * $cos(th - i_lag + 2.0 * PI / 3.0)));
            stb = 1'b1;
            t_s++;
            @(negedge clk);
            stb = 1'b0;
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state
        check(locked == 1'b0, "R10 locked", int'(locked), 0);
        check(shift_angle == 16'sd10923, "R10 shift", int'(shift_angle), 10923);
        check(pf_angle == 16'sd0, "R10 pf", int'(pf_angle), 0);
        check(v_amp == '0 && i_amp == '0, "R10 amp", int'(v_amp), 0);
        rst_n = 1'b1;

        // R3: lock cannot rise before 256 strobes
        run_samples(255);
        check(locked == 1'b0, "R3 early lock", int'(locked), 0);
        run_samples(SETTLE - 255);

        for (int v = 0; v < NV; v++) begin
            int    exp_pf, exp_sh, mag;
            string rq;
            i_lag = real'(VEC_PF[v]) * PI / 180.0;
            i_pk  = real'(VEC_IA[v]);
            run_samples(SETTLE);
            exp_pf = deg2u(real'(VEC_PF[v]));
            exp_sh = deg2u(real'(VEC_SH[v]));
            mag = (VEC_PF[v] < 0) ? -VEC_PF[v] : VEC_PF[v];
            rq = (mag < 30) ? "R5 shift" : ((mag <= 60) ? "R6 shift" : "R7 shift");
            check(locked == 1'b1, "R3 lock", int'(locked), 1);
            check(ang_err(int'(pf_angle), exp_pf) <= TOL, "R2 pf", int'(pf_angle), exp_pf);
            check(ang_err(int'(shift_angle), exp_sh) <= TOL, rq, int'(shift_angle), exp_sh);
            check((shift_angle < 0) == (VEC_PF[v] < 0), "R8 sign", int'(shift_angle), exp_sh);
            check(int'(v_amp) > 15520 && int'(v_amp) < 16480, "R1 v_amp", int'(v_amp), 16000);
            check(int'(i_amp) * 100 > VEC_IA[v] * 97 && int'(i_amp) * 100 < VEC_IA[v] * 103,
                  "R1 i_amp", int'(i_amp), VEC_IA[v]);
        end

        // R9: no strobe, no change
        begin
            logic signed [15:0] s0, p0;
            s0 = shift_angle;
            p0 = pf_angle;
            repeat (6) @(negedge clk);
            check(shift_angle == s0, "R9 shift hold", int'(shift_angle), int'(s0));
            check(pf_angle == p0, "R9 pf hold", int'(pf_angle), int'(p0));
        end

        // R4: a sudden current phase step drops lock and forces the 60 degree default
        i_lag = i_lag + 120.0 * PI / 180.0;
        run_samples(12);
        check(locked == 1'b0, "R4 unlock", int'(locked), 0);
        check(shift_angle == 16'sd10923, "R4 default shift", int'(shift_angle), 10923);

        run_samples(SETTLE);
        check(locked == 1'b1, "R3 relock", int'(locked), 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule